// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the system reset from two digital events: a supply-good flag from an external comparator, and a one-cycle watchdog expiry pulse. The supply flag can change at any time, so it passes through a synchronizer before the block uses it. Reset is active while the synchronized flag is low. It is released only after the flag has stayed high, without a single low sample, for a parameterized number of clock cycles (`HOLD_CYC`).

A watchdog expiry that arrives while reset is released starts a reset pulse of the same length. The block drives reset in both polarities. It also drives a one-cycle abort strobe, so that a control-register write already in progress is dropped at the moment reset becomes active. A bus-inhibit level stays high while the supply is seen as low.

The controller is a four-state machine:

- `ST_BROWNOUT`: the supply is low.
- `ST_PWR_HOLD`: the supply has recovered and the hold count is running.
- `ST_RUN`: reset is released.
- `ST_WDOG_HOLD`: a hold started by the watchdog.

The transitions are:

- `T_LOW`: from any state to `ST_BROWNOUT` when the synchronized flag is low. This takes priority over all others.
- `T_RECOVER`: from `ST_BROWNOUT` to `ST_PWR_HOLD`. It clears the counter.
- `T_PWR_DONE`: from `ST_PWR_HOLD` to `ST_RUN` when the count reaches `HOLD_CYC-1`.
- `T_WDOG`: from `ST_RUN` to `ST_WDOG_HOLD` on an expiry pulse. It clears the counter.
- `T_WDOG_DONE`: from `ST_WDOG_HOLD` to `ST_RUN` when the count reaches `HOLD_CYC-1`.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_n` is low, and after it rises until the supply is seen high, `rst_o`=1, `rst_n_o`=0, `bus_inhibit_o`=1 and `wr_abort_o`=0.
- R2: A low level on `supply_ok_i` driven while reset is released makes `rst_o` high at the third rising edge after the change, and not before.
- R3: `supply_ok_i` goes through a two-flop synchronizer. A change becomes visible to the state machine after two rising edges.
- R4: When `supply_ok_i` rises and stays high, `rst_o` falls at exactly the `HOLD_CYC+3`-th rising edge after the change: two edges of synchronizer, one edge for `T_RECOVER`, then `HOLD_CYC` cycles in `ST_PWR_HOLD`.
- R5: A low sample of the flag during a hold restarts the count from zero. A one-cycle low on `supply_ok_i` during `ST_PWR_HOLD` releases reset `HOLD_CYC+4` edges after the glitch starts.
- R6: A `wdt_expire_i` pulse sampled while reset is released makes `rst_o` high at that edge. `rst_o` then falls `HOLD_CYC` edges later if the supply stays high.
- R7: `rst_n_o` is always the complement of `rst_o`.
- R8: `wr_abort_o` is high for exactly the first cycle of each reset that follows a released period, and is low at all other times.
- R9: `bus_inhibit_o` is high exactly while the state machine is in `ST_BROWNOUT`. It implies `rst_o`.
- R10: `wdt_expire_i` has no effect while reset is already active. The hold in progress still ends at its usual edge.
- R11: A supply drop during a watchdog hold moves the block to `ST_BROWNOUT`, and `bus_inhibit_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low logic reset |
| supply_ok_i | input | 1 | Asynchronous flag: supply above trip point |
| wdt_expire_i | input | 1 | Synchronous one-cycle watchdog expiry pulse |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |
| wr_abort_o | output | 1 | One-cycle strobe that aborts pending register writes |
| bus_inhibit_o | output | 1 | High while the supply is seen below the trip point |

## Verification
The embedded properties check the cycle-local rules on every cycle:

- a low synchronized flag forces reset on the next edge;
- reset only falls after a high flag;
- a watchdog pulse during `ST_RUN` asserts reset;
- the abort strobe never lasts two cycles;
- inhibit implies reset;
- the counter stays in range.

Only the bench scenarios can show the exact release latency of `HOLD_CYC` cycles, the restart after a glitch, that a watchdog pulse during a hold is ignored, and the synchronizer delay. The bench measures these in edges against a cycle-level reference model.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [1:0] {
        ST_BROWNOUT  = 2'd0,
        ST_PWR_HOLD  = 2'd1,
        ST_RUN       = 2'd2,
        ST_WDOG_HOLD = 2'd3
    } rsq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) pipe[0] <= 1'b0;
                    else        pipe[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) pipe[g] <= 1'b0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/rsq_hold_cnt.sv
module rsq_hold_cnt #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                cnt <= '0;
        else if (clr_i)            cnt <= '0;
        else if (en_i && !done_o)  cnt <= cnt + 1'b1;
    end

    assign done_o = (cnt == LAST);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= LAST); // R4
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (cnt == '0) || (HOLD_CYC == 1)); // R5
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic supply_s_i,
    input  logic wdt_i,
    input  logic cnt_done_i,
    output logic cnt_clr_o,
    output logic cnt_en_o,
    output logic rst_o,
    output logic inhibit_o,
    output logic abort_o
);
    rsq_state_e state, state_nxt;
    logic       was_run;

    // transition selection
    always_comb begin
        state_nxt = state;
        cnt_clr_o = 1'b0;
        if (!supply_s_i) begin
            state_nxt = ST_BROWNOUT;                 // T_LOW
        end else begin
            unique case (state)
                ST_BROWNOUT: begin
                    state_nxt = ST_PWR_HOLD;         // T_RECOVER
                    cnt_clr_o = 1'b1;
                end
                ST_PWR_HOLD: begin
                    if (cnt_done_i) state_nxt = ST_RUN;   // T_PWR_DONE
                end
                ST_RUN: begin
                    if (wdt_i) begin
                        state_nxt = ST_WDOG_HOLD;    // T_WDOG
                        cnt_clr_o = 1'b1;
                    end
                end
                ST_WDOG_HOLD: begin
                    if (cnt_done_i) state_nxt = ST_RUN;   // T_WDOG_DONE
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_BROWNOUT;
        else        state <= state_nxt;
    end

    // output process
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) was_run <= 1'b0;
        else        was_run <= (state == ST_RUN);
    end

    always_comb begin
        cnt_en_o  = (state == ST_PWR_HOLD) || (state == ST_WDOG_HOLD);
        rst_o     = (state != ST_RUN);
        inhibit_o = (state == ST_BROWNOUT);
        abort_o   = rst_o && was_run;
    end

    AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !supply_s_i |=> rst_o && inhibit_o); // R2
    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_o) |-> $past(supply_s_i) && $past(cnt_done_i)); // R4
    AST_WDOG_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_o && wdt_i) |=> rst_o); // R6
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        abort_o |=> !abort_o); // R8
    AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |-> abort_o); // R8
    AST_INHIBIT_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        inhibit_o |-> rst_o); // R9
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int HOLD_CYC    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok_i,
    input  logic wdt_expire_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic wr_abort_o,
    output logic bus_inhibit_o
);
    logic supply_s;
    logic cnt_clr, cnt_en, cnt_done;
    logic rst_int;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .async_i (supply_ok_i),
        .sync_o  (supply_s)
    );

    rsq_hold_cnt #(.HOLD_CYC(HOLD_CYC)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .clr_i  (cnt_clr),
        .en_i   (cnt_en),
        .done_o (cnt_done)
    );

    rsq_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .supply_s_i (supply_s),
        .wdt_i      (wdt_expire_i),
        .cnt_done_i (cnt_done),
        .cnt_clr_o  (cnt_clr),
        .cnt_en_o   (cnt_en),
        .rst_o      (rst_int),
        .inhibit_o  (bus_inhibit_o),
        .abort_o    (wr_abort_o)
    );

    assign rst_o   = rst_int;
    assign rst_n_o = ~rst_int;
endmodule

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 24;
    localparam int LIMIT      = 150000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sup = 1'b0;
    logic wdt = 1'b0;
    logic rst, rst_n, abrt, inh;
    int   total = 0, bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_seq #(.HOLD_CYC(HOLD)) u_supply_reset_seq (
        .clk(clk), .por_n(por_n), .supply_ok_i(sup), .wdt_expire_i(wdt),
        .rst_o(rst), .rst_n_o(rst_n), .wr_abort_o(abrt), .bus_inhibit_o(inh)
    );

    // reference model: 0 brownout, 1 power hold, 2 run, 3 watchdog hold
    logic m_s1, m_s2, m_was;
    int   m_st, m_cnt;
    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_s1 <= 0; m_s2 <= 0; m_was <= 0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= sup; m_s2 <= m_s1; m_was <= (m_st == 2);
            if (!m_s2) m_st <= 0;
            else case (m_st)
                0: begin m_st <= 1; m_cnt <= 0; end
                1, 3: if (m_cnt == HOLD-1) m_st <= 2; else m_cnt <= m_cnt + 1;
                default: if (wdt) begin m_st <= 3; m_cnt <= 0; end
            endcase
        end
    end

    function automatic logic exp_rst();   return m_st != 2; endfunction
    function automatic logic exp_inh();   return m_st == 0; endfunction
    function automatic logic exp_abort(); return (m_st != 2) && m_was; endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // continuous model comparison, away from the active edge
    always @(negedge clk) if (por_n) begin
        chk("R4 rst_o vs model", rst, exp_rst());
        chk("R7 rst_n_o complement", rst_n, !rst);
        chk("R9 bus_inhibit_o vs model", inh, exp_inh());
        chk("R8 wr_abort_o vs model", abrt, exp_abort());
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // count edges until rst equals val
    task automatic edges_until(logic val, int maxn, output int n);
        n = 0;
        while (rst !== val && n < maxn) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic settle_run();
        int n;
        sup = 1'b1;
        edges_until(1'b0, HOLD + 20, n);
        @(negedge clk);
    endtask

    initial begin
        int n;
        int seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 rst_o during por", rst, 1);
        chk("R1 rst_n_o during por", rst_n, 0);
        chk("R1 bus_inhibit during por", inh, 1);
        chk("R1 wr_abort during por", abrt, 0);
        por_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 rst_o supply low after por", rst, 1);
        chk("R1 wr_abort low at start", abrt, 0);

        // R3 / R4: release latency
        sup = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 inhibit still high after two edges", inh, 1);
        @(negedge clk);
        chk("R3 inhibit low at third edge", inh, 0);
        n = 3;
        while (rst !== 1'b0 && n < HOLD + 20) begin @(negedge clk); n++; end
        chk("R4 release edges", n, HOLD + 3);

        // R2: drop
        repeat (3) @(negedge clk);
        sup = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 rst_o still low at edge two", rst, 0);
        @(negedge clk);
        chk("R2 rst_o high at edge three", rst, 1);
        chk("R8 abort on drop", abrt, 1);
        chk("R9 inhibit on drop", inh, 1);
        @(negedge clk);
        chk("R8 abort one cycle", abrt, 0);

        // R5: glitch during hold
        sup = 1'b1;
        repeat (3 + HOLD/2) @(negedge clk);
        sup = 1'b0;
        @(negedge clk);
        sup = 1'b1;
        n = 1;
        while (rst !== 1'b0 && n < 2*HOLD + 20) begin @(negedge clk); n++; end
        chk("R5 release after glitch", n, HOLD + 4);

        // R6: watchdog pulse
        repeat (2) @(negedge clk);
        wdt = 1'b1;
        @(negedge clk);
        wdt = 1'b0;
        chk("R6 rst_o after wdt", rst, 1);
        chk("R8 abort after wdt", abrt, 1);
        chk("R6 no inhibit on wdt", inh, 0);
        // R10: further pulse during hold is ignored
        repeat (HOLD/2) @(negedge clk);
        wdt = 1'b1;
        @(negedge clk);
        wdt = 1'b0;
        n = HOLD/2 + 1;
        while (rst !== 1'b0 && n < 2*HOLD + 20) begin @(negedge clk); n++; end
        chk("R10 wdt during hold ignored, release edge", n, HOLD);

        // R11: supply drop during watchdog hold
        @(negedge clk);
        wdt = 1'b1;
        @(negedge clk);
        wdt = 1'b0;
        sup = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 inhibit after drop in wdog hold", inh, 1);
        chk("R11 rst_o stays high", rst, 1);
        settle_run();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) sup = ~sup;
            else if (r < 6 && !sup) sup = 1'b1;
            wdt = ($urandom_range(0, 99) < 2);
            @(negedge clk);
        end
        wdt = 1'b0;
        settle_run();
        chk("R4 released at end of random phase", rst, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule